// File: doc/BRIEF.md
# Card Detect Debounce Controller

This block conditions one external card-detect pin and reports whether a card is present. The raw pin passes through a synchroniser and then a software-selected polarity. Assertion of presence is qualified against a slow millisecond tick that comes from outside the block. Removal is reported at once, without waiting for the tick.

Software controls the block through one byte-wide register. It holds a debounce enable, a detect enable, a polarity select and two pad pull controls, and it returns the presence flag as a read-only bit. A power-down input bypasses the tick qualification but leaves detection running. A one-cycle event pulse marks every change of presence.

Top module: `card_detect_ctrl`

## Requirements
- R1: The register resets to 0x00. Its fields are: bit 7 debounce enable, bit 6 detect enable, bit 3 polarity, bit 2 pull-up enable (active low), bit 1 pull-down enable, bit 0 presence (read-only). Bits 5 and 4 always read 0.
- R2: With debounce enabled and power-down low, presence sets on the edge that registers the 64th tick seen while the conditioned input is continuously asserted, and not before.
- R3: When the conditioned input de-asserts, presence clears on the next clock edge after the synchroniser, with no tick delay.
- R4: With polarity 1 a high pin means a card is present; with polarity 0 a low pin means a card is present.
- R5: With detect enable 0, presence is 0 and the tick count is cleared, so re-enabling requires a full 64 ticks again.
- R6: With power-down high, or with debounce disabled, presence follows the conditioned input without waiting for ticks.
- R7: A drop of the conditioned input during qualification restarts the tick count from zero.
- R8: Each rising and each falling change of presence produces exactly one single-cycle event pulse, in the same cycle that presence changes.
- R9: Writes to bit 0 have no effect on presence.
- R10: The pull-up control output reflects bit 2 and the pull-down output reflects bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Detection clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw card-detect pin, asynchronous |
| ms_tick_i | input | 1 | One-cycle 1 kHz timebase pulse |
| pwrdn_i | input | 1 | Power-down: bypass tick qualification |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data including presence |
| pull_up_n_o | output | 1 | Pad pull-up enable, active low |
| pull_down_o | output | 1 | Pad pull-down enable |
| card_present_o | output | 1 | Presence flag |
| card_event_o | output | 1 | One-cycle pulse on any presence change |

## Verification
Qualification is tried with an input that stays asserted for exactly 63 ticks and then 64, which separates an off-by-one counter from a correct one. An input that drops after 30 ticks and one interrupted by a detect-disable show whether the count restarts or wrongly carries over. Removal from a qualified state checks the immediate path, and both polarity settings with the pin held high and low show whether the sense is inverted. Power-down and debounce-disabled runs with no ticks show the bypass, and event pulses are counted across every transition.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  localparam int unsigned BIT_DEB  = 7;
  localparam int unsigned BIT_EN   = 6;
  localparam int unsigned BIT_POL  = 3;
  localparam int unsigned BIT_PU_N = 2;
  localparam int unsigned BIT_PD   = 1;
  localparam int unsigned BIT_PRES = 0;

  typedef struct packed {
    logic deb_en;
    logic det_en;
    logic pol;
    logic pu_n;
    logic pd_en;
  } ctrl_t;
endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else if (i == 0) stg_q[i] <= d_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdet_ctrl_reg.sv
module cdet_ctrl_reg
  import cdet_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       present_i,
  output ctrl_t      ctrl_o,
  output logic [7:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata_i[5:4], wdata_i[BIT_PRES]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.deb_en <= wdata_i[BIT_DEB];
      ctrl_q.det_en <= wdata_i[BIT_EN];
      ctrl_q.pol    <= wdata_i[BIT_POL];
      ctrl_q.pu_n   <= wdata_i[BIT_PU_N];
      ctrl_q.pd_en  <= wdata_i[BIT_PD];
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_DEB]  = ctrl_q.deb_en;
    rdata_o[BIT_EN]   = ctrl_q.det_en;
    rdata_o[BIT_POL]  = ctrl_q.pol;
    rdata_o[BIT_PU_N] = ctrl_q.pu_n;
    rdata_o[BIT_PD]   = ctrl_q.pd_en;
    rdata_o[BIT_PRES] = present_i;
  end

  assign ctrl_o = ctrl_q;

  assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[7:1] == ($past(wdata_i[7:1]) & 7'b1100111)));
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[5:4] == 2'b00);
endmodule

// File: rtl/cdet_debounce.sv
module cdet_debounce #(
  parameter int unsigned TICKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic deb_en_i,
  input  logic bypass_i,
  input  logic level_i,
  input  logic tick_i,
  output logic present_o,
  output logic event_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pres_q, pres_d, evt_q;

  always_comb begin
    cnt_d  = cnt_q;
    pres_d = pres_q;
    if (!en_i || !level_i) begin
      cnt_d  = '0;
      pres_d = 1'b0;
    end else if (bypass_i || !deb_en_i) begin
      cnt_d  = LIMIT;  // qualified: hold at limit
      pres_d = 1'b1;
    end else begin
      if (tick_i && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
      if (cnt_d == LIMIT) pres_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pres_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pres_q <= pres_d;
      evt_q  <= pres_d ^ pres_q;
    end
  end

  assign present_o = pres_q;
  assign event_o   = evt_q;

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_no_early_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pres_q && en_i && deb_en_i && !bypass_i && cnt_q < LIMIT - 1'b1) |=> !pres_q);
  assert_drop_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i |=> (!pres_q && cnt_q == '0));
  assert_disable_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pres_q && cnt_q == '0));
endmodule

// File: rtl/card_detect_ctrl.sv
module card_detect_ctrl
  import cdet_pkg::*;
#(
  parameter int unsigned DEB_TICKS   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       ms_tick_i,
  input  logic       pwrdn_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       pull_up_n_o,
  output logic       pull_down_o,
  output logic       card_present_o,
  output logic       card_event_o
);
  ctrl_t ctrl;
  logic  pin_sync, level, present, event_p;

  cdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign level = ctrl.det_en && (pin_sync == ctrl.pol);

  cdet_debounce #(.TICKS(DEB_TICKS)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl.det_en),
    .deb_en_i (ctrl.deb_en),
    .bypass_i (pwrdn_i),
    .level_i  (level),
    .tick_i   (ms_tick_i),
    .present_o(present),
    .event_o  (event_p)
  );

  cdet_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .present_i(present),
    .ctrl_o   (ctrl),
    .rdata_o  (reg_rdata_o)
  );

  assign pull_up_n_o    = ctrl.pu_n;
  assign pull_down_o    = ctrl.pd_en;
  assign card_present_o = present;
  assign card_event_o   = event_p;

  assert_event_on_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_present_o != $past(card_present_o)) |-> card_event_o);
  assert_event_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_event_o |=> !card_event_o || (card_present_o != $past(card_present_o)));
  assert_bit0_mirrors_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] == card_present_o);
endmodule

// File: tb/tb_card_detect_ctrl.sv
module tb_card_detect_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic       ms_tick_i = 1'b0;
  logic       pwrdn_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       pull_up_n_o, pull_down_o, card_present_o, card_event_o;

  int n_tests = 0;
  int n_fail  = 0;
  int ev_cnt  = 0;
  bit done    = 1'b0;

  card_detect_ctrl dut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  always @(posedge clk_i) if (rst_ni && card_event_o) ev_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    cyc(1);
    reg_we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick_i = 1'b1; cyc(1);
      ms_tick_i = 1'b0; cyc(2);
    end
  endtask

  task automatic clean();
    wr(8'h00); pin_i = 1'b0; pwrdn_i = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    check("R1 reset rdata", reg_rdata_o, 8'h00);
    check("R1 reset present", card_present_o, 0);
    check("R10 reset pulls", {pull_up_n_o, pull_down_o}, 2'b00);
  endtask

  task automatic t_regs();
    wr(8'hFF); cyc(3);
    check("R1 readback reserved zero", reg_rdata_o, 8'hCE);
    check("R10 pull outputs set", {pull_up_n_o, pull_down_o}, 2'b11);
    wr(8'h01); cyc(3);
    check("R9 bit0 write ignored", reg_rdata_o, 8'h00);
    check("R10 pull outputs clear", {pull_up_n_o, pull_down_o}, 2'b00);
  endtask

  task automatic t_disabled();
    clean();
    wr(8'h08); pin_i = 1'b1; cyc(5);
    check("R5 disabled no presence", card_present_o, 0);
  endtask

  task automatic t_bypass();
    int e0;
    clean();
    e0 = ev_cnt;
    wr(8'h48); pin_i = 1'b1; cyc(4);
    check("R6 no-debounce presence", card_present_o, 1);
    check("R8 one event on rise", ev_cnt - e0, 1);
    pin_i = 1'b0; cyc(4);
    check("R3 removal", card_present_o, 0);
    check("R8 one event on fall", ev_cnt - e0, 2);
  endtask

  task automatic t_polarity();
    clean();
    wr(8'h40); pin_i = 1'b0; cyc(4);
    check("R4 pol0 low=present", card_present_o, 1);
    pin_i = 1'b1; cyc(4);
    check("R4 pol0 high=absent", card_present_o, 0);
    wr(8'h48); cyc(4);
    check("R4 pol1 high=present", card_present_o, 1);
  endtask

  task automatic t_debounce();
    int e0;
    clean();
    wr(8'hC8); pin_i = 1'b1; cyc(4);
    e0 = ev_cnt;
    ticks(63);
    check("R2 63 ticks not present", card_present_o, 0);
    ms_tick_i = 1'b1; cyc(1); ms_tick_i = 1'b0;
    check("R2 64th tick present", card_present_o, 1);
    check("R8 event same cycle", card_event_o, 1);
    cyc(1);
    check("R8 event single cycle", card_event_o, 0);
    check("R8 event count", ev_cnt - e0, 1);
    ticks(5);
    check("R2 stays present", card_present_o, 1);
    pin_i = 1'b0; cyc(2);
    check("R3 still set before sync", card_present_o, 1);
    cyc(1);
    check("R3 immediate clear", card_present_o, 0);
  endtask

  task automatic t_restart();
    clean();
    wr(8'hC8); pin_i = 1'b1; cyc(4);
    ticks(30);
    pin_i = 1'b0; cyc(4); pin_i = 1'b1; cyc(4);
    ticks(63);
    check("R7 restart after drop", card_present_o, 0);
    ticks(1);
    check("R7 full count after drop", card_present_o, 1);
  endtask

  task automatic t_reenable();
    clean();
    wr(8'hC8); pin_i = 1'b1; cyc(4);
    ticks(40);
    wr(8'h88); cyc(2); wr(8'hC8); cyc(2);
    ticks(63);
    check("R5 count cleared by disable", card_present_o, 0);
    ticks(1);
    check("R5 full count after re-enable", card_present_o, 1);
  endtask

  task automatic t_pwrdn();
    clean();
    wr(8'hC8); pwrdn_i = 1'b1; pin_i = 1'b1; cyc(4);
    check("R6 power-down bypass", card_present_o, 1);
    pin_i = 1'b0; cyc(4);
    check("R6 power-down removal", card_present_o, 0);
    pwrdn_i = 1'b0;
  endtask

  initial begin
    cyc(3); rst_ni = 1'b1; cyc(1);
    t_reset();
    t_regs();
    t_disabled();
    t_bypass();
    t_polarity();
    t_debounce();
    t_restart();
    t_reenable();
    t_pwrdn();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule